// File: doc/BRIEF.md
# Multidrop Address-Filtering Receive Front End

This block sits between a 9-bit serial receiver and the receive FIFO of a UART used on an RS-485 multidrop bus. Each received character carries 8 data bits and a ninth tag bit. A tag of 1 marks a station address and a tag of 0 marks a data byte. The block decides for each character whether it reaches the FIFO, what error flag goes with it, and whether a line-status interrupt is raised. It also keeps the receiver-on state that controls whether data bytes are accepted.

Two filtering policies are offered. In normal multidrop mode every address is passed up and flagged, and software decides whether to turn reception on. In automatic mode the block compares each address with a programmed station character. A match turns reception on, and a mismatch turns it off, with no action from software. Software then only needs to end a message. When multidrop operation is off, the block passes every character straight through.

Top module: `mdrop_rx_filter`

## Requirements
- R1: With `mdrop_en`=0, every character strobe produces a push one cycle later. `push_data` equals `chr_data` and `push_err`=0. No interrupt is raised and `rx_on` is left unchanged.
- R2: In normal mode (`mdrop_en`=1, `auto_en`=0) with `rx_on`=0, a character with `chr_tag`=0 is discarded. A character with `chr_tag`=1 is pushed with `push_err`=1.
- R3: In normal mode with `rx_on`=1, a data character is pushed with `push_err`=0. An address character is pushed with `push_err`=1, and `rx_on` stays 1.
- R4: In automatic mode (`mdrop_en`=1, `auto_en`=1) with `rx_on`=0, data characters and addresses whose data bits differ from `station_chr` are discarded, and `rx_on` stays 0.
- R5: In automatic mode, an address equal to `station_chr` is pushed with `push_err`=1 (the tag bit) and sets `rx_on` to 1 on the next cycle. While `rx_on`=1, data characters are pushed with `push_err`=0.
- R6: In automatic mode, an address that does not match, received with `rx_on`=1, is not pushed, and `rx_on` becomes 0 on the next cycle.
- R7: A `sw_rx_off` pulse makes `rx_on` 0 on the next cycle, and every later data character is refused. A character in the same cycle as the pulse is judged by the earlier state.
- R8: A software write overrides an automatic change made in the same cycle. If `sw_rx_on` and `sw_rx_off` are both high, `rx_on` becomes 0.
- R9: `lsi` rises one cycle after a pushed address (R2, R3, R5), but only if `lsi_en` was 1 with the character. Once set, it holds until an `lsi_ack` cycle that has no new event. An event in the same cycle as the acknowledge keeps `lsi` at 1.
- R10: After reset, `push`, `lsi` and `rx_on` are 0.
- R11: `push` is high only in the cycle right after a character strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_vld | input | 1 | One-cycle strobe: a received character is present |
| chr_data | input | DATA_W | Received data bits |
| chr_tag | input | 1 | Ninth bit: 1 = address, 0 = data |
| mdrop_en | input | 1 | Multidrop filtering on |
| auto_en | input | 1 | Automatic address matching (with mdrop_en) |
| station_chr | input | DATA_W | Programmed station address |
| sw_rx_on | input | 1 | Software strobe: turn reception on |
| sw_rx_off | input | 1 | Software strobe: turn reception off |
| lsi_en | input | 1 | Line-status interrupt enable |
| lsi_ack | input | 1 | Clears the line-status interrupt |
| push | output | 1 | FIFO write strobe |
| push_data | output | DATA_W | Data written to the FIFO |
| push_err | output | 1 | Error flag written with the data |
| lsi | output | 1 | Sticky line-status interrupt |
| rx_on | output | 1 | Receiver-on state |

## Verification
The bench sweeps every data value with both tag values, in all three modes, starting from each receiver state. This shows where each design error would appear. A comparator that ignores the tag would let a data byte equal to the station character switch reception on. A mismatch rule applied while reception is off, or a missing one, would show as a wrong `rx_on`. Separate directed cases check the cycle in which a software strobe coincides with a character or with an automatic change. They also check an acknowledge that coincides with a new address event. A design that let the automatic path win, applied the write one character late, or let the acknowledge win would leave the wrong `rx_on` or `lsi`.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

   typedef enum logic [1:0] {
      MD_BYPASS = 2'd0,
      MD_NORMAL = 2'd1,
      MD_AUTO   = 2'd2
   } md_mode_e;

   typedef struct packed {
      logic accept;
      logic err;
      logic lsi_evt;
      logic auto_set;
      logic auto_clr;
   } md_verdict_t;

   function automatic md_mode_e md_mode(input logic mdrop_en, input logic auto_en);
      if (!mdrop_en)    return MD_BYPASS;
      else if (auto_en) return MD_AUTO;
      else              return MD_NORMAL;
   endfunction

endpackage

// File: rtl/mdrop_classify.sv
module mdrop_classify #(
   parameter int DATA_W = 8
) (
   input  logic              tag,
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] station,
   output logic              is_addr,
   output logic              hit
);
   always_comb begin
      is_addr = tag;
      hit     = tag && (data == station);
   end
endmodule

// File: rtl/mdrop_verdict.sv
module mdrop_verdict
   import mdrop_pkg::*;
(
   input  md_mode_e    mode,
   input  logic        rx_on,
   input  logic        is_addr,
   input  logic        hit,
   output md_verdict_t vd
);
   always_comb begin
      vd = '0;
      unique case (mode)
         MD_BYPASS: begin
            vd.accept = 1'b1;
         end
         MD_NORMAL: begin
            vd.accept  = is_addr || rx_on;
            vd.err     = is_addr;
            vd.lsi_evt = is_addr;
         end
         MD_AUTO: begin
            if (hit) begin
               vd.accept   = 1'b1;
               vd.err      = 1'b1;
               vd.lsi_evt  = 1'b1;
               vd.auto_set = !rx_on;
            end else if (is_addr) begin
               vd.auto_clr = rx_on;
            end else begin
               vd.accept = rx_on;
            end
         end
         default: vd = '0;
      endcase
   end
endmodule

// File: rtl/mdrop_enable_ctl.sv
module mdrop_enable_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic chr_vld,
   input  logic auto_set,
   input  logic auto_clr,
   input  logic sw_on,
   input  logic sw_off,
   output logic rx_on
);
   logic rx_nxt;

   always_comb begin
      rx_nxt = rx_on;
      if (sw_off)                   rx_nxt = 1'b0;
      else if (sw_on)               rx_nxt = 1'b1;
      else if (chr_vld && auto_set) rx_nxt = 1'b1;
      else if (chr_vld && auto_clr) rx_nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_on <= 1'b0;
      else        rx_on <= rx_nxt;
   end
endmodule

// File: rtl/mdrop_irq_flag.sv
module mdrop_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic enable,
   input  logic ack,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flag <= 1'b0;
      else if (set_evt && enable) flag <= 1'b1;
      else if (ack)               flag <= 1'b0;
   end
endmodule

// File: rtl/mdrop_push_stage.sv
module mdrop_push_stage #(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_err,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_data,
   output logic              out_err
);
   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_vld  <= 1'b0;
               out_data <= '0;
               out_err  <= 1'b0;
            end else begin
               out_vld <= in_vld;
               if (in_vld) begin
                  out_data <= in_data;
                  out_err  <= in_err;
               end
            end
         end
      end else begin : g_comb
         always_comb begin
            out_vld  = in_vld;
            out_data = in_data;
            out_err  = in_err;
         end
      end
   endgenerate
endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
   import mdrop_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chr_vld,
   input  logic [DATA_W-1:0] chr_data,
   input  logic              chr_tag,
   input  logic              mdrop_en,
   input  logic              auto_en,
   input  logic [DATA_W-1:0] station_chr,
   input  logic              sw_rx_on,
   input  logic              sw_rx_off,
   input  logic              lsi_en,
   input  logic              lsi_ack,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output logic              push_err,
   output logic              lsi,
   output logic              rx_on
);
   localparam int MIN_W = 5;
   localparam int MAX_W = 16;

   generate
      if (DATA_W < MIN_W || DATA_W > MAX_W) begin : g_bad_width
         $error("mdrop_rx_filter: DATA_W out of range");
      end
   endgenerate

   md_mode_e    mode;
   logic        is_addr;
   logic        hit;
   md_verdict_t vd;
   logic        take;

   assign mode = md_mode(mdrop_en, auto_en);

   mdrop_classify #(.DATA_W(DATA_W)) u_cls (
      .tag     (chr_tag),
      .data    (chr_data),
      .station (station_chr),
      .is_addr (is_addr),
      .hit     (hit)
   );

   mdrop_verdict u_vd (
      .mode    (mode),
      .rx_on   (rx_on),
      .is_addr (is_addr),
      .hit     (hit),
      .vd      (vd)
   );

   assign take = chr_vld && vd.accept;

   mdrop_enable_ctl u_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .chr_vld  (chr_vld),
      .auto_set (vd.auto_set),
      .auto_clr (vd.auto_clr),
      .sw_on    (sw_rx_on),
      .sw_off   (sw_rx_off),
      .rx_on    (rx_on)
   );

   mdrop_irq_flag u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (chr_vld && vd.lsi_evt),
      .enable  (lsi_en),
      .ack     (lsi_ack),
      .flag    (lsi)
   );

   mdrop_push_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_push (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (take),
      .in_data  (chr_data),
      .in_err   (vd.err),
      .out_vld  (push),
      .out_data (push_data),
      .out_err  (push_err)
   );
endmodule

// File: rtl/mdrop_rx_filter_chk.sv
module mdrop_rx_filter_chk #(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chr_vld,
   input logic [DATA_W-1:0] chr_data,
   input logic              chr_tag,
   input logic              mdrop_en,
   input logic              auto_en,
   input logic [DATA_W-1:0] station_chr,
   input logic              sw_rx_on,
   input logic              sw_rx_off,
   input logic              lsi_en,
   input logic              lsi_ack,
   input logic              push,
   input logic              push_err,
   input logic              lsi,
   input logic              rx_on
);
   p_sw_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rx_off |=> !rx_on);

   p_sw_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rx_on && !sw_rx_off |=> rx_on);

   p_auto_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      chr_vld && mdrop_en && auto_en && chr_tag && chr_data == station_chr && !sw_rx_off
      |=> rx_on);

   p_auto_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chr_vld && mdrop_en && auto_en && chr_tag && chr_data != station_chr && !sw_rx_on
      |=> !rx_on);

   p_lsi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lsi && !lsi_ack |=> lsi);

   p_lsi_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !lsi && !lsi_en |=> !lsi);

   generate
      if (OUT_REG) begin : g_reg_props
         p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
            chr_vld && !mdrop_en |=> push && !push_err);

         p_data_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
            chr_vld && mdrop_en && !auto_en && !chr_tag && !rx_on |=> !push);

         p_addr_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
            chr_vld && mdrop_en && !auto_en && chr_tag |=> push && push_err);

         p_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
            chr_vld && mdrop_en && auto_en && chr_tag && chr_data != station_chr |=> !push);

         p_no_stray_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !chr_vld |=> !push);
      end
   endgenerate
endmodule

bind mdrop_rx_filter mdrop_rx_filter_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .chr_vld     (chr_vld),
   .chr_data    (chr_data),
   .chr_tag     (chr_tag),
   .mdrop_en    (mdrop_en),
   .auto_en     (auto_en),
   .station_chr (station_chr),
   .sw_rx_on    (sw_rx_on),
   .sw_rx_off   (sw_rx_off),
   .lsi_en      (lsi_en),
   .lsi_ack     (lsi_ack),
   .push        (push),
   .push_err    (push_err),
   .lsi         (lsi),
   .rx_on       (rx_on)
);

// File: tb/mdrop_rx_filter_tb.sv
module mdrop_rx_filter_tb;
   localparam int W = 8;
   localparam logic [W-1:0] STN = 8'hA5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chr_vld = 0, chr_tag = 0, mdrop_en = 0, auto_en = 0;
   logic sw_rx_on = 0, sw_rx_off = 0, lsi_en = 0, lsi_ack = 0;
   logic [W-1:0] chr_data = '0;
   logic [W-1:0] station_chr = STN;
   logic push, push_err, lsi, rx_on;
   logic [W-1:0] push_data;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   mdrop_rx_filter #(.DATA_W(W), .OUT_REG(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .chr_data(chr_data),
      .chr_tag(chr_tag), .mdrop_en(mdrop_en), .auto_en(auto_en),
      .station_chr(station_chr), .sw_rx_on(sw_rx_on), .sw_rx_off(sw_rx_off),
      .lsi_en(lsi_en), .lsi_ack(lsi_ack), .push(push), .push_data(push_data),
      .push_err(push_err), .lsi(lsi), .rx_on(rx_on)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic set_rx(input bit v);
      @(negedge clk);
      sw_rx_on = v; sw_rx_off = !v; lsi_ack = 1'b1;
      @(negedge clk);
      sw_rx_on = 0; sw_rx_off = 0; lsi_ack = 0;
   endtask

   task automatic drive_chr(input bit t, input logic [W-1:0] d);
      @(negedge clk);
      chr_vld = 1'b1; chr_tag = t; chr_data = d;
      @(negedge clk);
      chr_vld = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(push == 0, "R10 push", push, 0);
      chk(lsi == 0, "R10 lsi", lsi, 0);
      chk(rx_on == 0, "R10 rx_on", rx_on, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // exhaustive sweep: mode x start state x tag x data
      for (int m = 0; m < 3; m++) begin
         for (int r = 0; r < 2; r++) begin
            for (int t = 0; t < 2; t++) begin
               for (int d = 0; d < 256; d++) begin
                  bit acc, err, ev, nr, len, hit;
                  string tg;
                  mdrop_en = (m != 0);
                  auto_en  = (m == 2);
                  set_rx(r[0]);
                  chk(rx_on == r[0], "R8 sw write", rx_on, r);
                  chk(lsi == 0, "R9 ack clears", lsi, 0);
                  len = (d[3:0] != 4'h3);
                  lsi_en = len;
                  hit = (d[7:0] == STN);
                  if (m == 0) begin
                     acc = 1; err = 0; ev = 0; nr = r[0]; tg = "R1";
                  end else if (m == 1) begin
                     acc = t[0] | r[0]; err = t[0]; ev = t[0]; nr = r[0];
                     tg = r[0] ? "R3" : "R2";
                  end else begin
                     if (t[0] && hit) begin
                        acc = 1; err = 1; ev = 1; nr = 1; tg = "R5";
                     end else if (t[0]) begin
                        acc = 0; err = 0; ev = 0; nr = 0; tg = r[0] ? "R6" : "R4";
                     end else begin
                        acc = r[0]; err = 0; ev = 0; nr = r[0]; tg = r[0] ? "R5" : "R4";
                     end
                  end
                  drive_chr(t[0], d[7:0]);
                  chk(push == acc, tg, push, acc);
                  if (acc) begin
                     chk(push_data == d[7:0], tg, push_data, d);
                     chk(push_err == err, tg, push_err, err);
                  end
                  chk(rx_on == nr, tg, rx_on, nr);
                  chk(lsi == (ev & len), "R9 lsi set", lsi, ev & len);
                  @(negedge clk);
                  chk(push == 0, "R11 single push", push, 0);
               end
            end
         end
      end

      // R7: same-cycle character judged by old state, then refused
      mdrop_en = 1; auto_en = 0; lsi_en = 1;
      set_rx(1'b1);
      @(negedge clk);
      chr_vld = 1; chr_tag = 0; chr_data = 8'h3C; sw_rx_off = 1;
      @(negedge clk);
      chr_vld = 0; sw_rx_off = 0;
      chk(push == 1, "R7 same-cycle char", push, 1);
      chk(rx_on == 0, "R7 rx_off", rx_on, 0);
      drive_chr(1'b0, 8'h3D);
      chk(push == 0, "R7 later char refused", push, 0);

      // R8: software off overrides auto match enable
      auto_en = 1;
      set_rx(1'b0);
      @(negedge clk);
      chr_vld = 1; chr_tag = 1; chr_data = STN; sw_rx_off = 1;
      @(negedge clk);
      chr_vld = 0; sw_rx_off = 0;
      chk(push == 1, "R8 match pushed", push, 1);
      chk(rx_on == 0, "R8 off wins over auto", rx_on, 0);

      // R8: software on overrides auto mismatch disable
      set_rx(1'b1);
      @(negedge clk);
      chr_vld = 1; chr_tag = 1; chr_data = 8'h11; sw_rx_on = 1;
      @(negedge clk);
      chr_vld = 0; sw_rx_on = 0;
      chk(push == 0, "R8 mismatch dropped", push, 0);
      chk(rx_on == 1, "R8 on wins over auto", rx_on, 1);

      // R8: both strobes -> off
      @(negedge clk);
      sw_rx_on = 1; sw_rx_off = 1;
      @(negedge clk);
      sw_rx_on = 0; sw_rx_off = 0;
      chk(rx_on == 0, "R8 both strobes", rx_on, 0);

      // R9: event with ack keeps lsi, ack alone clears
      auto_en = 0; lsi_en = 1;
      drive_chr(1'b1, 8'h42);
      chk(lsi == 1, "R9 raised", lsi, 1);
      repeat (3) @(negedge clk);
      chk(lsi == 1, "R9 sticky", lsi, 1);
      @(negedge clk);
      chr_vld = 1; chr_tag = 1; chr_data = 8'h43; lsi_ack = 1;
      @(negedge clk);
      chr_vld = 0; lsi_ack = 0;
      chk(lsi == 1, "R9 event beats ack", lsi, 1);
      @(negedge clk);
      lsi_ack = 1;
      @(negedge clk);
      lsi_ack = 0;
      chk(lsi == 0, "R9 ack clears", lsi, 0);

      // R1: bypass does not touch rx_on
      mdrop_en = 0;
      drive_chr(1'b1, 8'h99);
      chk(rx_on == 0 && push == 1 && push_err == 0, "R1 bypass", {rx_on, push, push_err}, 3'b010);

      @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule